// File: doc/BRIEF.md
# Serial FPGA Configuration Sequencer

This block loads a configuration image into an FPGA through its slave serial port. It drives the active-low program line, the configuration clock and the serial data line. It reads back the active-low init line and the done line, and both pass through two-flop synchronisers first. A single `start` pulse launches one load.

For a full load, the block holds the program line low and confirms that the device has pulled init low. It then gives a short run of dummy clocks and releases the program line. It polls init with further dummy bursts until init goes high. Next it takes payload bytes from a valid/ready byte stream and shifts each one out MSB first. Finally it issues single extra clocks while it waits for done. A partial load, chosen by the `partial` input, leaves the program line high and starts at the dummy clocks.

A failed attempt restarts from the beginning, up to a set number of attempts. The upstream stream must therefore be able to replay the payload from its first byte. The block ends with a one-cycle success or failure pulse and a three-bit error code.

Top module: `cfg_serial_loader`

## Requirements
- R1: While reset is held, `cfg_prog_n` is 1 and `cfg_clk`, `cfg_dout`, `s_ready`, `load_ok` and `load_fail` are all 0.
- R2: In a full load, `cfg_prog_n` stays low for exactly PROG_HOLD cycles before init is checked. If the synchronised init line is still high at that point, the attempt fails with error code 1.
- R3: A partial load never drives `cfg_prog_n` low. It begins with DUMMY_CLOCKS clocks and then polls init.
- R4: In a full load, exactly DUMMY_CLOCKS configuration clocks are issued while `cfg_prog_n` is still low. Only then is the line released.
- R5: While init reads low after release, the block issues bursts of DUMMY_CLOCKS clocks. If init is still low after INIT_POLLS bursts, the attempt fails with error code 2.
- R6: Payload bytes are shifted out MSB first. `cfg_dout` holds steady across every rising edge of `cfg_clk`. `s_ready` is high only in the cycles that wait for the next byte, and never while `cfg_clk` is high. A byte accepted with `s_last` = 1 ends the payload.
- R7: Every configuration clock outside payload shifting carries `cfg_dout` = 0.
- R8: After the payload, the block checks done before each single extra clock. If done is high, `load_ok` pulses with `err_code` = 0.
- R9: During the done wait, if init reads low while done is low, the attempt fails with error code 3.
- R10: If done is still low after DONE_CLOCKS extra clocks, the attempt fails with error code 4.
- R11: A failed attempt restarts from the first step. `load_fail` pulses, with the last attempt's nonzero code, only after ATTEMPTS attempts have all failed. `load_ok` and `load_fail` never pulse together.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low synchronous reset |
| start | input | 1 | Pulse that starts a load when idle |
| partial | input | 1 | Sampled at start: 1 selects a partial load |
| s_data | input | 8 | Payload byte |
| s_valid | input | 1 | Payload byte present |
| s_last | input | 1 | Marks the final payload byte |
| s_ready | output | 1 | Block accepts a byte this cycle |
| cfg_prog_n | output | 1 | Active-low program line to the device |
| cfg_clk | output | 1 | Configuration clock |
| cfg_dout | output | 1 | Serial configuration data |
| cfg_init_n | input | 1 | Active-low init line from the device |
| cfg_done | input | 1 | Done line from the device |
| load_ok | output | 1 | One-cycle success pulse |
| load_fail | output | 1 | One-cycle final failure pulse |
| err_code | output | 3 | 0 none, 1 init stuck high, 2 init timeout, 3 init low during load, 4 done timeout |

## Verification
The bench builds the block with CLK_DIV = 3, PROG_HOLD = 8, INIT_POLLS = 4, DONE_CLOCKS = 6 and ATTEMPTS = 5. With these values, every timeout path and the full five-attempt retry sequence finish in a few hundred cycles. The exact number of clocks in each phase can then be counted and compared. A CLK_DIV of 3 also gives the synchronisers time to settle inside one configuration clock half-period, so the device model can answer on the very next edge.

// File: rtl/cfg_serial_loader.sv
module cfg_serial_loader #(
  parameter int CLK_DIV      = 2,
  parameter int PROG_HOLD    = 200,
  parameter int DUMMY_CLOCKS = 3,
  parameter int INIT_POLLS   = 100000,
  parameter int DONE_CLOCKS  = 1000,
  parameter int ATTEMPTS     = 5
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       start,
  input  logic       partial,
  input  logic [7:0] s_data,
  input  logic       s_valid,
  input  logic       s_last,
  output logic       s_ready,
  output logic       cfg_prog_n,
  output logic       cfg_clk,
  output logic       cfg_dout,
  input  logic       cfg_init_n,
  input  logic       cfg_done,
  output logic       load_ok,
  output logic       load_fail,
  output logic [2:0] err_code
);
  localparam int PHW  = $clog2(2 * CLK_DIV);
  localparam int HW   = $clog2(PROG_HOLD + 1);
  localparam int PW   = $clog2(INIT_POLLS + 1);
  localparam int DW   = $clog2(DONE_CLOCKS + 1);
  localparam int AW   = $clog2(ATTEMPTS + 1);
  localparam int BMAX = (DUMMY_CLOCKS > 8) ? DUMMY_CLOCKS : 8;
  localparam int BW   = $clog2(BMAX + 1);

  localparam logic [PHW-1:0] PH_HI     = PHW'(CLK_DIV);
  localparam logic [PHW-1:0] PH_LAST   = PHW'(2 * CLK_DIV - 1);
  localparam logic [HW-1:0]  HOLD_LAST = HW'(PROG_HOLD - 1);
  localparam logic [PW-1:0]  POLL_MAX  = PW'(INIT_POLLS);
  localparam logic [DW-1:0]  DONE_MAX  = DW'(DONE_CLOCKS);
  localparam logic [AW-1:0]  TRY_LAST  = AW'(ATTEMPTS - 1);
  localparam logic [BW-1:0]  B_DUMMY   = BW'(DUMMY_CLOCKS);
  localparam logic [BW-1:0]  B_BYTE    = BW'(8);
  localparam logic [BW-1:0]  B_ONE     = BW'(1);

  typedef enum logic [2:0] {
    S_IDLE, S_BEGIN, S_PROG, S_PRE, S_POLL, S_FETCH, S_SHIFT, S_DWAIT
  } st_t;

  st_t            st;
  logic           part_r, last_r, prog_r;
  logic [HW-1:0]  hold;
  logic [PW-1:0]  polls;
  logic [DW-1:0]  dcnt;
  logic [AW-1:0]  tries;
  logic [BW-1:0]  burst;
  logic [PHW-1:0] ph;
  logic [7:0]     sr;
  logic [1:0]     init_q, done_q;
  logic [2:0]     err_now;

  wire init_s  = init_q[1];
  wire done_s  = done_q[1];
  wire clk_run = (burst != '0);
  wire cyc_end = clk_run && (ph == PH_LAST);

  assign cfg_prog_n = prog_r;
  assign cfg_clk    = clk_run && (ph >= PH_HI);
  assign cfg_dout   = (st == S_SHIFT) && sr[7];
  assign s_ready    = (st == S_FETCH);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      init_q <= '0;
      done_q <= '0;
    end else begin
      init_q <= {init_q[0], cfg_init_n};
      done_q <= {done_q[0], cfg_done};
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n || !clk_run || cyc_end) ph <= '0;
    else                               ph <= ph + 1'b1;
  end

  always_comb begin
    err_now = 3'd0;
    if (!clk_run) begin
      case (st)
        S_PROG:  if (hold == HOLD_LAST && init_s) err_now = 3'd1;
        S_POLL:  if (!init_s && polls == POLL_MAX) err_now = 3'd2;
        S_DWAIT: if (!done_s) begin
                   if (!init_s)               err_now = 3'd3;
                   else if (dcnt == DONE_MAX) err_now = 3'd4;
                 end
        default: err_now = 3'd0;
      endcase
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      st <= S_IDLE;  part_r <= 1'b0;  last_r <= 1'b0;  prog_r <= 1'b1;
      hold <= '0;  polls <= '0;  dcnt <= '0;  tries <= '0;  burst <= '0;
      sr <= '0;  load_ok <= 1'b0;  load_fail <= 1'b0;  err_code <= 3'd0;
    end else begin
      load_ok   <= 1'b0;
      load_fail <= 1'b0;
      if (cyc_end) begin
        burst <= burst - 1'b1;
        if (st == S_SHIFT) sr <= {sr[6:0], 1'b0};
      end
      if (err_now != 3'd0) begin
        err_code <= err_now;
        prog_r   <= 1'b1;
        if (tries == TRY_LAST) begin
          load_fail <= 1'b1;
          st        <= S_IDLE;
        end else begin
          tries <= tries + 1'b1;
          st    <= S_BEGIN;
        end
      end else if (!clk_run) begin
        case (st)
          S_IDLE: if (start) begin
            tries  <= '0;
            part_r <= partial;
            st     <= S_BEGIN;
          end
          S_BEGIN: begin
            hold <= '0;
            if (part_r) begin
              burst <= B_DUMMY;
              st    <= S_PRE;
            end else begin
              prog_r <= 1'b0;
              st     <= S_PROG;
            end
          end
          S_PROG: if (hold == HOLD_LAST) begin
            burst <= B_DUMMY;
            st    <= S_PRE;
          end else hold <= hold + 1'b1;
          S_PRE: begin
            prog_r <= 1'b1;
            polls  <= '0;
            st     <= S_POLL;
          end
          S_POLL: if (init_s) st <= S_FETCH;
          else begin
            polls <= polls + 1'b1;
            burst <= B_DUMMY;
          end
          S_FETCH: if (s_valid) begin
            sr     <= s_data;
            last_r <= s_last;
            burst  <= B_BYTE;
            st     <= S_SHIFT;
          end
          S_SHIFT: begin
            dcnt <= '0;
            st   <= last_r ? S_DWAIT : S_FETCH;
          end
          S_DWAIT: if (done_s) begin
            load_ok  <= 1'b1;
            err_code <= 3'd0;
            st       <= S_IDLE;
          end else begin
            dcnt  <= dcnt + 1'b1;
            burst <= B_ONE;
          end
          default: st <= S_IDLE;
        endcase
      end
    end
  end

  p_ok_code_r8: assert property (@(posedge clk) disable iff (!rst_n)
    load_ok |-> err_code == 3'd0)
    else $error("success pulse with nonzero code");

  p_fail_code_r11: assert property (@(posedge clk) disable iff (!rst_n)
    load_fail |-> err_code != 3'd0)
    else $error("failure pulse without a code");

  p_one_result_r11: assert property (@(posedge clk) disable iff (!rst_n)
    !(load_ok && load_fail))
    else $error("success and failure together");

  p_din_setup_r6: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(cfg_clk) |-> $stable(cfg_dout))
    else $error("data moved at a rising configuration clock");

  p_ready_clk_low_r6: assert property (@(posedge clk) disable iff (!rst_n)
    s_ready |-> !cfg_clk)
    else $error("byte requested while clock high");

  p_prog_width_r2: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(cfg_prog_n) && (PROG_HOLD > 1) |=> !cfg_prog_n)
    else $error("program pulse too short");
endmodule

// File: tb/cfg_serial_loader_tb.sv
`timescale 1ns/1ps
module cfg_serial_loader_tb_top;
  localparam int DIV = 3, HOLD = 8, POLLS = 4, DCLK = 6, TRIES = 5;

  logic clk = 1'b0, rst_n = 1'b0, start = 1'b0, partial = 1'b0;
  logic s_valid = 1'b0, s_last = 1'b0;
  logic [7:0] s_data = 8'h00;
  logic s_ready, prog_n, cclk, dout, load_ok, load_fail;
  logic [2:0] err_code;
  logic init_drv = 1'b1, done_drv = 1'b0;

  always #2.5 clk = ~clk;

  cfg_serial_loader #(
    .CLK_DIV(DIV), .PROG_HOLD(HOLD), .DUMMY_CLOCKS(3),
    .INIT_POLLS(POLLS), .DONE_CLOCKS(DCLK), .ATTEMPTS(TRIES)
  ) dut_i (
    .clk(clk), .rst_n(rst_n), .start(start), .partial(partial),
    .s_data(s_data), .s_valid(s_valid), .s_last(s_last), .s_ready(s_ready),
    .cfg_prog_n(prog_n), .cfg_clk(cclk), .cfg_dout(dout),
    .cfg_init_n(init_drv), .cfg_done(done_drv),
    .load_ok(load_ok), .load_fail(load_fail), .err_code(err_code)
  );

  int n_tests = 0, n_fail = 0;
  int stuck_n = 0, init_delay = 1, done_after = 1;
  bit never_rise = 0, crc_err = 0, done_never = 0, cmp_en = 0;
  int prog_falls = 0, pre_rises = 0, poll_rises = 0, post_rises = 0;
  int post = 0, bits = 0, nbits = 0, rise = 0, din_bad = 0, idx = 0;
  bit armed = 0, fire = 0;
  logic [7:0] sh = 8'h00;
  logic [7:0] pay[$];
  logic [7:0] exp_q[$];
  logic [7:0] rx_q[$];

  task automatic chk(input bit c, input string what, input int act, input int exp);
    n_tests++;
    if (!c) begin
      n_fail++;
      $display("FAIL %s: got %0d expected %0d", what, act, exp);
    end
  endtask

  // device model: program line falling edge
  initial forever begin
    @(negedge prog_n);
    prog_falls++;
    init_drv = (prog_falls <= stuck_n) ? 1'b1 : 1'b0;
    done_drv = 1'b0;
    bits = 0; post = 0; rise = 0; armed = 0;
  end

  // device model: configuration clock rising edge
  initial forever begin
    @(posedge cclk);
    if (!prog_n) begin
      pre_rises++;
      if (dout) din_bad++;
    end else if (!armed) begin
      poll_rises++;
      if (dout) din_bad++;
      if (!init_drv && !never_rise) begin
        rise++;
        if (rise >= init_delay) init_drv = 1'b1;
      end
    end else if (bits < nbits) begin
      sh = {sh[6:0], dout};
      bits++;
      if (bits % 8 == 0) rx_q.push_back(sh);
      if (bits == nbits && crc_err) init_drv = 1'b0;
    end else begin
      post++; post_rises++;
      if (dout) din_bad++;
      if (!done_never && post >= done_after) done_drv = 1'b1;
    end
  end

  // byte-stream source, replays the payload on every attempt
  initial forever begin
    @(negedge clk);
    if (fire) idx = (idx + 1 >= pay.size()) ? 0 : idx + 1;
    if (pay.size() > 0) begin
      s_valid = 1'b1; s_data = pay[idx]; s_last = (idx == pay.size() - 1);
    end else begin
      s_valid = 1'b0; s_data = 8'h00; s_last = 1'b0;
    end
    fire = s_valid && s_ready;
    if (fire) armed = 1'b1;
  end

  // scoreboard monitor
  initial forever begin
    logic [7:0] b, e;
    @(negedge clk);
    while (rx_q.size() > 0) begin
      b = rx_q.pop_front();
      if (cmp_en) begin
        if (exp_q.size() == 0) chk(1'b0, "R6 unexpected byte", b, -1);
        else begin
          e = exp_q.pop_front();
          chk(b == e, "R6 payload byte", b, e);
        end
      end
    end
  end

  task automatic setup(input int stk, input bit nr, input int idl, input bit crc,
                       input bit dn, input int da, input bit cmp);
    stuck_n = stk; never_rise = nr; init_delay = idl; crc_err = crc;
    done_never = dn; done_after = da; cmp_en = cmp;
    idx = 0; fire = 0; nbits = 8 * pay.size();
    exp_q.delete(); rx_q.delete();
    if (cmp) foreach (pay[i]) exp_q.push_back(pay[i]);
    prog_falls = 0; pre_rises = 0; poll_rises = 0; post_rises = 0;
    post = 0; bits = 0; rise = 0; din_bad = 0; armed = 0;
    init_drv = 1'b1; done_drv = 1'b0;
    repeat (3) @(negedge clk);
  endtask

  task automatic run(input bit part, output bit ok, output bit fl,
                     output int code, output int low_cyc);
    partial = part; ok = 0; fl = 0; code = -1; low_cyc = 0;
    @(negedge clk); start = 1'b1;
    @(negedge clk); start = 1'b0;
    for (int i = 0; i < 20000; i++) begin
      if (!prog_n) low_cyc++;
      if (load_ok || load_fail) begin
        ok = load_ok; fl = load_fail; code = int'(err_code);
        break;
      end
      @(negedge clk);
    end
    repeat (4) @(negedge clk);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    n_fail++;
    $display("FAIL watchdog: got %0d expected %0d", 0, 1);
    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end

  initial begin
    bit ok, fl;
    int code, lc;
    repeat (3) @(negedge clk);
    chk(prog_n === 1'b1, "R1 program line idle high", int'(prog_n), 1);
    chk(cclk === 1'b0 && dout === 1'b0, "R1 clock and data low", int'({cclk, dout}), 0);
    chk(s_ready === 1'b0 && load_ok === 1'b0 && load_fail === 1'b0,
        "R1 no ready or result", int'({s_ready, load_ok, load_fail}), 0);
    rst_n = 1'b1;

    // full load, success
    pay = '{8'hA5, 8'h3C, 8'h81, 8'h00};
    setup(0, 0, 1, 0, 0, 2, 1);
    run(0, ok, fl, code, lc);
    chk(ok && !fl, "R8 full load succeeds", int'(ok), 1);
    chk(code == 0, "R8 success code", code, 0);
    chk(prog_falls == 1, "R2 one program pulse", prog_falls, 1);
    chk(pre_rises == 3, "R4 clocks before release", pre_rises, 3);
    chk(poll_rises == 3, "R5 one poll burst", poll_rises, 3);
    chk(post_rises == 2, "R8 extra clocks until done", post_rises, 2);
    chk(din_bad == 0, "R7 dummy clocks carry zero", din_bad, 0);
    chk(exp_q.size() == 0, "R6 all bytes received", exp_q.size(), 0);

    // partial load
    pay = '{8'h5A, 8'hF0, 8'h0F};
    setup(0, 0, 1, 0, 0, 1, 1);
    run(1, ok, fl, code, lc);
    chk(ok && code == 0, "R3 partial load succeeds", code, 0);
    chk(prog_falls == 0, "R3 no program pulse", prog_falls, 0);
    chk(poll_rises == 3, "R3 leading dummy clocks", poll_rises, 3);
    chk(post_rises == 1, "R8 single extra clock", post_rises, 1);
    chk(din_bad == 0, "R7 dummy data partial", din_bad, 0);
    chk(exp_q.size() == 0, "R6 partial bytes received", exp_q.size(), 0);

    // slow init release
    pay = '{8'hC3};
    setup(0, 0, 5, 0, 0, 1, 1);
    run(0, ok, fl, code, lc);
    chk(ok && code == 0, "R5 slow init then success", code, 0);
    chk(poll_rises == 6, "R5 two poll bursts", poll_rises, 6);

    // init never goes low during the program pulse
    pay = '{8'h11};
    setup(99, 0, 1, 0, 0, 1, 0);
    run(0, ok, fl, code, lc);
    chk(fl && !ok && code == 1, "R2 init stuck code", code, 1);
    chk(prog_falls == TRIES, "R11 attempts on init stuck", prog_falls, TRIES);
    chk(lc == TRIES * HOLD, "R2 program low width", lc, TRIES * HOLD);
    chk(pre_rises == 0, "R2 no clocks after stuck init", pre_rises, 0);

    // init never rises after release
    setup(0, 1, 1, 0, 0, 1, 0);
    run(0, ok, fl, code, lc);
    chk(fl && code == 2, "R5 init timeout code", code, 2);
    chk(poll_rises == TRIES * 3 * POLLS, "R5 poll clock count", poll_rises, TRIES * 3 * POLLS);
    chk(pre_rises == TRIES * 3, "R4 pre clocks per attempt", pre_rises, TRIES * 3);
    chk(din_bad == 0, "R7 poll clocks carry zero", din_bad, 0);

    // init low after payload, done low
    pay = '{8'h9E, 8'h42};
    setup(0, 0, 1, 1, 0, 1, 0);
    run(0, ok, fl, code, lc);
    chk(fl && code == 3, "R9 init low during load code", code, 3);
    chk(prog_falls == TRIES, "R11 attempts on load error", prog_falls, TRIES);

    // done never rises
    setup(0, 0, 1, 0, 1, 1, 0);
    run(0, ok, fl, code, lc);
    chk(fl && code == 4, "R10 done timeout code", code, 4);
    chk(post_rises == TRIES * DCLK, "R10 extra clocks per attempt", post_rises, TRIES * DCLK);

    // two failed attempts then success
    pay = '{8'h96};
    setup(2, 0, 1, 0, 0, 1, 1);
    run(0, ok, fl, code, lc);
    chk(ok && !fl && code == 0, "R11 success on third attempt", code, 0);
    chk(prog_falls == 3, "R11 attempt count", prog_falls, 3);
    chk(exp_q.size() == 0, "R6 byte after retries", exp_q.size(), 0);

    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end
endmodule